// File: doc/BRIEF.md
# Regulator Startup and Fault Supervisor

This block is the digital sequencer of a step-down converter. It takes synchronous flags from the analog front end and decides three things. First, whether the power stage may run. Second, whether the gate drivers must float, and whether the soft-start ramp must be forced back to zero. Third, whether the output is reported as good. Comparators, thresholds, the soft-start current source and temperature hysteresis all live outside the block. Their results arrive here as single-bit flags sampled on the block clock.

Starting requires three things together: both supply rails good and the enable request high. Four fault responses then coexist, each with a different policy:
- An overvoltage is filtered and then latched off.
- An overcurrent sample causes a one-cycle hiccup that floats the gates and restarts soft start. The fourth such strike locks the converter off.
- Over-temperature floats the gates only while its flag is high.
- A filtered undervoltage only withdraws power-good.

The overvoltage latch and the strike lock are cleared only by dropping a supply flag or enable.

Top module: `pwr_seq_supervisor`

## Requirements
- R1: `run` is high exactly when `vmain_ok`, `vint_ok` and `en_req` are all high, the overvoltage latch is clear and fewer than four overcurrent strikes are recorded. Whenever `run` is low, `gate_float` and `ss_clear` are high in the same cycle.
- R2: The undervoltage and overvoltage inputs take effect only after being sampled high on 35 consecutive clock edges. A pulse of 34 samples or fewer has no effect on any output.
- R3: A filtered undervoltage drops `pgood` on the next edge but leaves `run`, `gate_float` and `ss_clear` unchanged.
- R4: A filtered overvoltage sets a latch on the next edge. The latch drives `run` low and `pgood` low, which makes `gate_float` and `ss_clear` high. It stays set after the overvoltage input falls, until a supply flag or `en_req` drops.
- R5: An `oc_hit` sample while `run` is high and no hiccup is in progress starts a hiccup. For the one following cycle, `gate_float` and `ss_clear` are high and `oc_hit` is not counted again.
- R6: After the fourth counted strike, `run` stays low. The strike count returns to zero only when a supply flag or `en_req` drops, so four fresh strikes are needed to lock again.
- R7: While `hot_flag` is high, `gate_float` is high and `pgood` falls on the next edge. When the flag clears, the block returns to normal operation with no other action.
- R8: `pgood` is a register. It rises one edge after `run` is high, `gate_float` is low, `ss_done` is high, and neither filtered voltage fault is present.
- R9: During and right after reset, `pgood` is low and no strike, latch or filter state is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | block clock |
| rst_n | input | 1 | active-low asynchronous reset |
| vmain_ok | input | 1 | main supply within range |
| vint_ok | input | 1 | internal rail within range |
| en_req | input | 1 | enable request above its threshold |
| ss_done | input | 1 | soft-start ramp has passed its delay level |
| uv_raw | input | 1 | feedback below the undervoltage threshold (unfiltered) |
| ov_raw | input | 1 | feedback above the overvoltage threshold (unfiltered) |
| oc_hit | input | 1 | overcurrent sample from the low-side switch |
| hot_flag | input | 1 | over-temperature flag, hysteresis applied upstream |
| run | output | 1 | converter allowed to switch |
| gate_float | output | 1 | both gate drivers to high impedance |
| ss_clear | output | 1 | discharge soft start to zero |
| pgood | output | 1 | output in regulation |

## Verification
Timing differs by output:
- `run`, `gate_float` and `ss_clear` are combinational from the present flags and the stored state. They are due in the same cycle as the input change.
- `pgood`, the overvoltage latch and the hiccup flag each change one edge after their cause.
- A filtered fault appears after the 35th high sample. Its effect on `pgood` or the latch therefore lands on the 36th edge.

The bench keeps a behavioural model that advances on each rising edge. It compares all four outputs at every falling edge, after settling, with inputs changed only after that comparison. This makes every off-by-one in the filter window or the strike count visible in a specific cycle.

// File: rtl/svr_pkg.sv
package svr_pkg;

    // Registered state kept in the top-level sequencer.
    typedef struct packed {
        logic ov_latched;
        logic pgood;
    } seq_state_t;

endpackage

// File: rtl/svr_deglitch.sv
module svr_deglitch #(
    parameter int HOLD = 35
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic flt
);
    localparam int CW = $clog2(HOLD + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flt;
    } dg_t;

    dg_t dg_d, dg_q;

    always_comb begin
        dg_d = dg_q;
        if (!raw) begin
            dg_d.cnt = '0;
            dg_d.flt = 1'b0;
        end else begin
            if (dg_q.cnt != CW'(HOLD)) dg_d.cnt = dg_q.cnt + 1'b1;
            dg_d.flt = (dg_q.cnt >= CW'(HOLD - 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dg_q <= '0;
        else        dg_q <= dg_d;
    end

    assign flt = dg_q.flt;

    // R2: a filtered flag is only ever high after the raw input was high
    assert_flt_needs_raw_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dg_q.flt |-> $past(raw));

    // R2: the filtered flag rises only once the run length is complete
    assert_flt_full_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dg_q.flt) |-> (dg_q.cnt == CW'(HOLD)));

endmodule

// File: rtl/svr_oc_strikes.sv
module svr_oc_strikes #(
    parameter int STRIKES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic evt,
    output logic lock,
    output logic hiccup
);
    localparam int CW = $clog2(STRIKES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          hic;
    } oc_t;

    oc_t oc_d, oc_q;

    always_comb begin
        oc_d = oc_q;
        if (clr) begin
            oc_d.cnt = '0;
            oc_d.hic = 1'b0;
        end else begin
            oc_d.hic = evt;
            if (evt && (oc_q.cnt < CW'(STRIKES))) oc_d.cnt = oc_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) oc_q <= '0;
        else        oc_q <= oc_d;
    end

    assign lock   = (oc_q.cnt >= CW'(STRIKES));
    assign hiccup = oc_q.hic;

    // R6: the count never exceeds the strike limit
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        oc_q.cnt <= CW'(STRIKES));

    // R6: without a clear, the count holds or steps up by one
    assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (oc_q.cnt == $past(oc_q.cnt)) || (oc_q.cnt == $past(oc_q.cnt) + 1'b1));

    // R6: once locked, only a clear releases the lock
    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !clr) |=> lock);

endmodule

// File: rtl/pwr_seq_supervisor.sv
module pwr_seq_supervisor #(
    parameter int FILT_CYCLES = 35,
    parameter int OC_STRIKES  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vmain_ok,
    input  logic vint_ok,
    input  logic en_req,
    input  logic ss_done,
    input  logic uv_raw,
    input  logic ov_raw,
    input  logic oc_hit,
    input  logic hot_flag,
    output logic run,
    output logic gate_float,
    output logic ss_clear,
    output logic pgood
);
    import svr_pkg::*;

    logic       path_ok;
    logic       uv_f;
    logic       ov_f;
    logic       oc_lock;
    logic       oc_hic;
    logic       oc_count_evt;
    seq_state_t st_d, st_q;

    assign path_ok = vmain_ok & vint_ok & en_req;

    svr_deglitch #(.HOLD(FILT_CYCLES)) u_uv_filt (
        .clk(clk), .rst_n(rst_n), .raw(uv_raw), .flt(uv_f)
    );

    svr_deglitch #(.HOLD(FILT_CYCLES)) u_ov_filt (
        .clk(clk), .rst_n(rst_n), .raw(ov_raw), .flt(ov_f)
    );

    assign oc_count_evt = oc_hit & run & ~oc_hic;

    svr_oc_strikes #(.STRIKES(OC_STRIKES)) u_oc (
        .clk(clk), .rst_n(rst_n), .clr(~path_ok), .evt(oc_count_evt),
        .lock(oc_lock), .hiccup(oc_hic)
    );

    assign run        = path_ok & ~st_q.ov_latched & ~oc_lock;
    assign gate_float = ~run | hot_flag | oc_hic;
    assign ss_clear   = ~run | oc_hic;
    assign pgood      = st_q.pgood;

    always_comb begin
        st_d            = st_q;
        st_d.ov_latched = path_ok & (st_q.ov_latched | ov_f);
        st_d.pgood      = run & ~gate_float & ss_done & ~uv_f & ~ov_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: a filtered overvoltage with the path up stops the converter next cycle
    assert_ov_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_f && path_ok) |=> !run);

    // R4: the latch survives while the enable path stays up
    assert_ov_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ov_latched && path_ok) |=> !run);

    // R8: power-good needs soft start complete in the previous cycle
    assert_pg_ss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pgood |-> $past(ss_done));

    // R7: heat withdraws power-good one edge later
    assert_hot_pg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hot_flag |=> !pgood);

    // R3: filtered undervoltage withdraws power-good one edge later
    assert_uv_pg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        uv_f |=> !pgood);

    // R1: a dropped path clears power-good next edge
    assert_path_pg_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !path_ok |=> !pgood);

endmodule

// File: tb/pwr_seq_supervisor_bench.sv
module pwr_seq_supervisor_bench;
    localparam int FILT = 35;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vmain_ok = 0, vint_ok = 0, en_req = 0, ss_done = 0;
    logic uv_raw = 0, ov_raw = 0, oc_hit = 0, hot_flag = 0;
    logic run, gate_float, ss_clear, pgood;

    int total = 0;
    int bad = 0;
    string cur_req = "R9";
    bit done = 0;

    always #2 clk = ~clk;

    pwr_seq_supervisor u_pwr_seq_supervisor (
        .clk(clk), .rst_n(rst_n), .vmain_ok(vmain_ok), .vint_ok(vint_ok),
        .en_req(en_req), .ss_done(ss_done), .uv_raw(uv_raw), .ov_raw(ov_raw),
        .oc_hit(oc_hit), .hot_flag(hot_flag), .run(run),
        .gate_float(gate_float), .ss_clear(ss_clear), .pgood(pgood)
    );

    // behavioural reference
    int uv_run = 0, ov_run = 0, strikes = 0;
    bit m_uvf = 0, m_ovf = 0, m_lat = 0, m_hic = 0, m_pg = 0;
    bit t_ok, t_run, t_gf, n_pg, n_lat, n_hic;

    always @(posedge clk) begin
        if (!rst_n) begin
            uv_run = 0; ov_run = 0; strikes = 0;
            m_uvf = 0; m_ovf = 0; m_lat = 0; m_hic = 0; m_pg = 0;
        end else begin
            t_ok  = vmain_ok && vint_ok && en_req;
            t_run = t_ok && !m_lat && (strikes < 4);
            t_gf  = !t_run || hot_flag || m_hic;
            n_pg  = t_run && !t_gf && ss_done && !m_uvf && !m_ovf;
            n_lat = t_ok && (m_lat || m_ovf);
            if (!t_ok) begin
                strikes = 0;
                n_hic = 0;
            end else begin
                n_hic = oc_hit && t_run && !m_hic;
                if (n_hic && strikes < 4) strikes++;
            end
            m_pg = n_pg; m_lat = n_lat; m_hic = n_hic;
            uv_run = uv_raw ? uv_run + 1 : 0;
            ov_run = ov_raw ? ov_run + 1 : 0;
            m_uvf = (uv_run >= FILT);
            m_ovf = (ov_run >= FILT);
        end
    end

    task automatic cmp(string req, string nm, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, nm, act, exp, $time);
        end
    endtask

    // one cycle: settle at the falling edge, compare all outputs to the model
    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            begin
                bit ok, er, eg, es;
                ok = vmain_ok && vint_ok && en_req;
                er = ok && !m_lat && (strikes < 4);
                eg = !er || hot_flag || m_hic;
                es = !er || m_hic;
                cmp(cur_req, "run", run, er);
                cmp(cur_req, "gate_float", gate_float, eg);
                cmp(cur_req, "ss_clear", ss_clear, es);
                cmp(cur_req, "pgood", pgood, m_pg);
            end
        end
    endtask

    task automatic strike();
        oc_hit = 1; step(1); oc_hit = 0; step(6);
    endtask

    initial begin
        // R9: reset state
        cur_req = "R9";
        step(3);
        cmp("R9", "pgood_in_reset", pgood, 1'b0);
        rst_n = 1; step(2);

        // R1 / R8: bring-up, power-good after soft start
        cur_req = "R1";
        vmain_ok = 1; vint_ok = 1; en_req = 1; step(4);
        cmp("R1", "run_up", run, 1'b1);
        cur_req = "R8";
        ss_done = 1; step(1);
        cmp("R8", "pgood_one_edge", pgood, 1'b1);
        step(3);

        // R2: 34-sample pulses have no effect
        cur_req = "R2";
        uv_raw = 1; step(FILT - 1); uv_raw = 0; step(3);
        ov_raw = 1; step(FILT - 1); ov_raw = 0; step(3);
        cmp("R2", "pgood_after_glitch", pgood, 1'b1);
        cmp("R2", "run_after_glitch", run, 1'b1);

        // R3: real undervoltage only drops power-good
        cur_req = "R3";
        uv_raw = 1; step(FILT + 4);
        cmp("R3", "pgood_uv", pgood, 1'b0);
        cmp("R3", "run_uv", run, 1'b1);
        uv_raw = 0; step(4);

        // R7: over-temperature, auto recovery
        cur_req = "R7";
        hot_flag = 1; step(5);
        cmp("R7", "float_hot", gate_float, 1'b1);
        hot_flag = 0; step(3);
        cmp("R7", "pgood_back", pgood, 1'b1);

        // R5: hiccups, back-to-back hit counted once
        cur_req = "R5";
        strike();
        oc_hit = 1; step(1);
        cmp("R5", "ss_clear_hic", ss_clear, 1'b1);
        step(1); oc_hit = 0; step(5);
        strike();

        // R6: fourth strike locks, toggle clears count
        cur_req = "R6";
        strike();
        cmp("R6", "locked", run, 1'b0);
        step(10);
        en_req = 0; step(2); en_req = 1; step(3);
        cmp("R6", "released", run, 1'b1);
        strike(); strike(); strike();
        cmp("R6", "three_fresh", run, 1'b1);
        vint_ok = 0; step(2); vint_ok = 1; step(3);

        // R4: overvoltage latch
        cur_req = "R4";
        ov_raw = 1; step(FILT + 2); ov_raw = 0; step(10);
        cmp("R4", "ov_latched", run, 1'b0);
        cmp("R4", "ov_pgood", pgood, 1'b0);
        vmain_ok = 0; step(2); vmain_ok = 1; step(3);
        cmp("R4", "ov_cleared", run, 1'b1);

        // R1: loss of a rail
        cur_req = "R1";
        vint_ok = 0; step(1);
        cmp("R1", "run_drop", run, 1'b0);
        cmp("R1", "float_drop", gate_float, 1'b1);
        vint_ok = 1; step(3);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired requirement=%s actual=hung expected=finished", cur_req);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule